// File: doc/BRIEF.md
# Fetch-Stage Branch Direction and Target Predictor

This block sits beside the fetch stage and predicts conditional not-equal branches. It keeps a small direct-mapped table. Each entry has a valid flag, an address tag, a stored target and a 2-bit saturating direction counter. The fetch stage presents a PC on the lookup port. In the same cycle the block answers with a predicted-taken flag and the address fetch should go to next. On a miss, that address is the fall-through address, PC+4.

The branch unit resolves each branch in a single cycle. It then drives the update port with the branch PC, the real outcome and the real target. An update that hits its entry trains the counter and refreshes the target. An update that misses claims the entry: it writes the tag and target, and the outcome is applied to a counter that starts from weakly taken. Instructions are 4 bytes wide and the first one sits at byte address 0. Address bits 7..4 select the entry and the bits above them form the tag.

Top module: `branch_target_predictor`

## Requirements
- R1: After reset every entry is invalid, so every lookup misses, and every direction counter holds the weakly-taken value 2'b10.
- R2: The entry index is PC bits 7..4 and the tag is PC bits 31..8. Two PCs that differ only in bits 3..0 share one entry. PCs that differ in bits 7..4 use separate entries.
- R3: A lookup that misses (invalid entry or tag mismatch) returns not-taken with target lookup PC + 4.
- R4: A lookup that hits returns taken exactly when bit 1 of the counter is set, using the encoding 00 strong not-taken, 01 weak not-taken, 10 weak taken, 11 strong taken. The returned target is the stored target.
- R5: An update that misses marks the entry valid and writes its tag and target. Its counter becomes 2'b11 for a taken outcome and 2'b01 for a not-taken outcome.
- R6: An update that hits moves the counter one step up for taken and one step down for not-taken, saturating at 2'b11 and 2'b00. It also overwrites the stored target.
- R7: An update whose tag differs from a valid entry's tag replaces that entry. After that, lookups with the old tag miss.
- R8: When a lookup and an update address the same entry in the same cycle, the lookup returns the state held before the update. The update becomes visible from the next cycle.
- R9: While the update enable is low, no entry state changes, whatever the other update inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_pc | input | PC_W | Fetch PC to predict |
| lk_taken | output | 1 | Predicted taken |
| lk_target | output | PC_W | Predicted next fetch address |
| up_en | input | 1 | Resolved-branch update strobe |
| up_pc | input | PC_W | PC of the resolved branch |
| up_taken | input | 1 | Actual branch outcome |
| up_target | input | PC_W | Actual branch target |

## Verification
The bench builds the block with its defaults: a 32-bit PC, 16 entries and an index starting at bit 4. With these values, bits 7..4 select the entry and a tag of 24 bits remains. Random PCs are drawn from three tags, all sixteen indexes and four word offsets. This makes aliasing, tag replacement, same-entry collisions between lookup and update, and saturation at both counter ends occur often. Directed sequences first walk one counter through every state and then cover the reset and disabled-update cases.

// File: rtl/branch_target_predictor.sv
module branch_target_predictor #(
  parameter int PC_W    = 32,
  parameter int ENTRIES = 16,
  parameter int IDX_LO  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] lk_pc,
  output logic            lk_taken,
  output logic [PC_W-1:0] lk_target,
  input  logic            up_en,
  input  logic [PC_W-1:0] up_pc,
  input  logic            up_taken,
  input  logic [PC_W-1:0] up_target
);
  localparam int IDX_W  = $clog2(ENTRIES);
  localparam int TAG_LO = IDX_LO + IDX_W;
  localparam int TAG_W  = PC_W - TAG_LO;
  localparam logic [1:0] WEAK_T = 2'b10;

  logic [ENTRIES-1:0]             vld;
  logic [ENTRIES-1:0][1:0]        ctr;
  logic [ENTRIES-1:0][TAG_W-1:0]  tag;
  logic [ENTRIES-1:0][PC_W-1:0]   tgt;

  wire [IDX_W-1:0] lk_idx = lk_pc[TAG_LO-1:IDX_LO];
  wire [TAG_W-1:0] lk_tag = lk_pc[PC_W-1:TAG_LO];
  wire [IDX_W-1:0] up_idx = up_pc[TAG_LO-1:IDX_LO];
  wire [TAG_W-1:0] up_tag = up_pc[PC_W-1:TAG_LO];

  wire lk_hit = vld[lk_idx] && (tag[lk_idx] == lk_tag);
  wire up_hit = vld[up_idx] && (tag[up_idx] == up_tag);

  assign lk_taken  = lk_hit && ctr[lk_idx][1];
  assign lk_target = lk_hit ? tgt[lk_idx] : lk_pc + PC_W'(4);

  wire [1:0] base = up_hit ? ctr[up_idx] : WEAK_T;
  logic [1:0] ctr_nx;
  always_comb begin
    if (up_taken) ctr_nx = (base == 2'b11) ? base : base + 2'b01;
    else          ctr_nx = (base == 2'b00) ? base : base - 2'b01;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
      ctr <= {ENTRIES{WEAK_T}};
      tag <= '0;
      tgt <= '0;
    end else if (up_en) begin
      vld[up_idx] <= 1'b1;
      ctr[up_idx] <= ctr_nx;
      tag[up_idx] <= up_tag;
      tgt[up_idx] <= up_target;
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (vld == '0) && (ctr == {ENTRIES{WEAK_T}}));

  assert_alloc_counter_R5: assert property (@(posedge clk) disable iff (!rst_n)
    up_en && !up_hit |=> vld[$past(up_idx)] && (tag[$past(up_idx)] == $past(up_tag))
      && (ctr[$past(up_idx)] == ($past(up_taken) ? 2'b11 : 2'b01)));

  assert_saturate_top_R6: assert property (@(posedge clk) disable iff (!rst_n)
    up_en && up_hit && up_taken && ctr[up_idx] == 2'b11 |=> ctr[$past(up_idx)] == 2'b11);

  assert_saturate_bottom_R6: assert property (@(posedge clk) disable iff (!rst_n)
    up_en && up_hit && !up_taken && ctr[up_idx] == 2'b00 |=> ctr[$past(up_idx)] == 2'b00);

  assert_target_written_R6: assert property (@(posedge clk) disable iff (!rst_n)
    up_en |=> tgt[$past(up_idx)] == $past(up_target));

  assert_idle_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !up_en |=> $stable(vld) && $stable(ctr) && $stable(tag) && $stable(tgt));
endmodule

// File: tb/branch_target_predictor_test.sv
`timescale 1ns/1ps
module branch_target_predictor_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] lk_pc = '0;
  logic        lk_taken;
  logic [31:0] lk_target;
  logic        up_en = 1'b0;
  logic [31:0] up_pc = '0;
  logic        up_taken = 1'b0;
  logic [31:0] up_target = '0;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic        m_vld [16];
  logic [23:0] m_tag [16];
  logic [1:0]  m_ctr [16];
  logic [31:0] m_tgt [16];

  always #10 clk = ~clk;

  branch_target_predictor uut (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_taken), .lk_target(lk_target),
    .up_en(up_en), .up_pc(up_pc), .up_taken(up_taken), .up_target(up_target));

  function automatic bit m_hit(input logic [31:0] pc);
    return m_vld[pc[7:4]] && (m_tag[pc[7:4]] == pc[31:8]);
  endfunction

  function automatic logic exp_taken(input logic [31:0] pc);
    return m_hit(pc) && m_ctr[pc[7:4]][1];
  endfunction

  function automatic logic [31:0] exp_target(input logic [31:0] pc);
    return m_hit(pc) ? m_tgt[pc[7:4]] : pc + 32'd4;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 16; i++) begin
      m_vld[i] = 0; m_tag[i] = '0; m_ctr[i] = 2'b10; m_tgt[i] = '0;
    end
  endtask

  task automatic model_update(input logic [31:0] pc, input logic t, input logic [31:0] tg);
    logic [1:0] b;
    b = m_hit(pc) ? m_ctr[pc[7:4]] : 2'b10;
    if (t) b = (b == 2'b11) ? b : b + 2'b01;
    else   b = (b == 2'b00) ? b : b - 2'b01;
    m_vld[pc[7:4]] = 1; m_tag[pc[7:4]] = pc[31:8];
    m_ctr[pc[7:4]] = b; m_tgt[pc[7:4]] = tg;
  endtask

  task automatic cyc(input string req, input logic [31:0] lpc, input logic ue,
                     input logic [31:0] upc, input logic ut, input logic [31:0] utg);
    logic et;
    logic [31:0] eg;
    @(negedge clk);
    lk_pc = lpc; up_en = ue; up_pc = upc; up_taken = ut; up_target = utg;
    #1;
    et = exp_taken(lpc);
    eg = exp_target(lpc);
    checks++;
    if (lk_taken !== et || lk_target !== eg) begin
      fails++;
      $display("FAIL %s pc=%h taken=%b/%b target=%h/%h (actual/expected)",
               req, lpc, lk_taken, et, lk_target, eg);
    end
    if (ue) model_update(upc, ut, utg);
  endtask

  task automatic look(input string req, input logic [31:0] lpc);
    cyc(req, lpc, 1'b0, 32'hFFFF_FFF0, 1'b0, 32'h0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    look("R1", 32'h0000_0000);
    look("R1", 32'h0000_01F0);
    look("R3", 32'h1234_5678);

    cyc("R8", 32'h0000_0100, 1'b1, 32'h0000_0100, 1'b1, 32'h0000_0040);
    look("R5", 32'h0000_0100);
    cyc("R8", 32'h0000_0230, 1'b1, 32'h0000_0230, 1'b0, 32'h0000_0500);
    look("R5", 32'h0000_0230);

    for (int k = 0; k < 2; k++) begin
      cyc("R6", 32'h0000_0100, 1'b1, 32'h0000_0100, 1'b1, 32'h0000_0044);
      look("R6", 32'h0000_0100);
    end
    for (int k = 0; k < 5; k++) begin
      cyc("R6", 32'h0000_0100, 1'b1, 32'h0000_0100, 1'b0, 32'h0000_0048);
      look("R4", 32'h0000_0100);
    end
    for (int k = 0; k < 3; k++) begin
      cyc("R6", 32'h0000_0100, 1'b1, 32'h0000_0100, 1'b1, 32'h0000_004C);
      look("R4", 32'h0000_0100);
    end

    look("R2", 32'h0000_010C);
    look("R2", 32'h0000_0110);
    look("R2", 32'h0000_0200);

    cyc("R7", 32'h0000_0104, 1'b1, 32'h0000_0200, 1'b1, 32'h0000_0080);
    look("R7", 32'h0000_0100);
    look("R7", 32'h0000_0208);

    cyc("R9", 32'h0000_0200, 1'b0, 32'h0000_0200, 1'b0, 32'h0000_0999);
    cyc("R9", 32'h0000_0200, 1'b0, 32'h0000_0300, 1'b1, 32'h0000_0777);
    look("R9", 32'h0000_0200);
    look("R9", 32'h0000_0300);

    for (int n = 0; n < 4000; n++) begin
      logic [31:0] a, b;
      a = {22'd0, 2'($urandom_range(0, 2)), 4'($urandom), 2'($urandom), 2'b00};
      b = ($urandom_range(0, 3) == 0) ? a :
          {22'd0, 2'($urandom_range(0, 2)), 4'($urandom), 2'($urandom), 2'b00};
      cyc("R4", a, 1'($urandom_range(0, 3) != 0), b, 1'($urandom), {$urandom} & 32'hFFFF_FFFC);
    end

    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    look("R1", 32'h0000_0100);
    look("R1", 32'h0000_0208);

    finish_run();
  end
endmodule